// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller beside a successive-approximation converter. Software programs a control word, a timing word and a prescaler word through plain write-enable ports. The block divides the peripheral clock into a timebase of ticks and then runs each conversion through three phases. First a warm-up window, then a sampling window, then a convert phase in which it waits for the converter to hand back a result. The result is latched into a data register and a sticky done flag is raised, which also drives the interrupt line.

In single-shot mode one conversion runs per start request. In continuous mode the block starts a new conversion each time a sample-period counter expires; that counter is measured in ticks from the previous start. Continuous operation ends only with an abort. The channel, reference, input-scale and measurement-type selections go straight through to the converter pins.

The converter side is a valid/ready pair. During the convert phase the block raises `conv_valid` and `res_ready` together and holds both until it accepts a result. The converter presents `res_valid` with `res_data` and must hold them until a cycle with `res_ready` high. A result offered outside the convert phase is not taken. The block never stalls the converter in any other way.

Top module: `adc_seq_top`

## Requirements
- R1: The control word reads back as follows: bit 0 mode, bit 3 measurement type, bits 6:4 scale, bits 10:8 conversion channel, bits 14:12 reference channel. Bits 1 (start), 2 (abort), 7, 11 and 15 always read 0.
- R2: `ch_sel`, `ref_sel`, `scale_code` and `meas_abs` equal the stored control fields. Channel codes 0-3 are external inputs, 4-5 are unused, 6 is the temperature sensor and 7 is the battery. `meas_abs` is 1 for absolute and 0 for differential.
- R3: One tick lasts P+1 clocks when the prescaler enable (prescale word bit 8) is 1, where P is prescale bits 7:0. It lasts one clock when the enable is 0. Ticks are counted from the start edge.
- R4: After a start, `warm_en` is high for max(W,1) ticks, where W is timing word bits 15:8.
- R5: `sample_en` follows warm-up directly and is high for max(S,1) ticks, where S is timing word bits 7:0.
- R6: In the convert phase `conv_valid` and `res_ready` stay high until `res_valid` is seen. On that edge `res_data` is latched into `data_out`. In single-shot mode `busy` then falls.
- R7: A capture sets the done flag (`stat_rdata[0]`, also `irq`), and the flag stays set. Writing 1 to status bit 0 clears it; writing 0 has no effect.
- R8: In continuous mode (mode 1), successive starts are max(R,1) ticks apart when a conversion fits in that period, where R is timing word bits 31:16.
- R9: An abort write (control bit 2) while continuous mode is stored puts the block in idle at the next edge. It discards a result offered on that edge and does not restart.
- R10: An abort write while single-shot mode is stored has no effect on the running conversion.
- R11: A start write while busy is ignored; the phases in progress are not restarted.
- R12: A control write with the start bit at 0 does not start a conversion.
- R13: The timing word reads back as written, and so do the 9 prescaler bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word read-back |
| dly_we | input | 1 | Timing word write enable |
| dly_wdata | input | 32 | Timing word: rate 31:16, warm-up 15:8, sample 7:0 |
| dly_rdata | output | 32 | Timing word read-back |
| psc_we | input | 1 | Prescaler word write enable |
| psc_wdata | input | 9 | Prescaler: enable bit 8, value 7:0 |
| psc_rdata | output | 9 | Prescaler read-back |
| stat_we | input | 1 | Status write enable (bit 0 write-one-to-clear) |
| stat_wdata | input | 2 | Status write data |
| stat_rdata | output | 2 | Status: bit 1 busy, bit 0 done |
| data_out | output | RES_W | Last captured result |
| irq | output | 1 | Interrupt, equal to the done flag |
| busy | output | 1 | Sequencer not idle |
| ch_sel | output | 3 | Conversion channel select to converter |
| ref_sel | output | 3 | Reference channel select to converter |
| scale_code | output | 3 | Input scale code to converter |
| meas_abs | output | 1 | Measurement type to converter |
| warm_en | output | 1 | Warm-up phase strobe |
| sample_en | output | 1 | Sampling phase strobe |
| conv_valid | output | 1 | Conversion request valid |
| res_ready | output | 1 | Ready to accept a result |
| res_valid | input | 1 | Result valid from converter |
| res_data | input | RES_W | Result from converter |

## Verification
The bench sweeps prescaler value and enable, warm-up count and sample count, including zero. It then checks the exact number of cycles each phase strobe is high. A design that let a zero count skip its phase, ran one tick short or long, or ignored the enable would be off by a whole tick there. Continuous runs measure the spacing between starts; a period counter that restarted at capture instead of at start would stretch that spacing. An abort is issued in the same cycle a result is offered, and again in single-shot mode. A start is repeated while busy. A design that gave capture priority over abort, honoured abort in single-shot mode, or restarted warm-up on a second start would change `data_out`, `busy` or the phase length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CTL_W   = 16;
  localparam int DLY_W   = 32;
  localparam int PH_W    = 8;
  localparam int RATE_W  = 16;
  localparam int PSC_W   = 8;
  localparam int SEL_W   = 3;
  localparam int STAT_W  = 2;

  localparam int CB_MODE  = 0;
  localparam int CB_GO    = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_ABS   = 3;
  localparam int CB_SCALE = 4;
  localparam int CB_CH    = 8;
  localparam int CB_REF   = 12;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WARM = 3'd1,
    ST_SAMP = 3'd2,
    ST_CONV = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] ref_sel;
    logic [SEL_W-1:0] ch_sel;
    logic [SEL_W-1:0] scale;
    logic             meas_abs;
    logic             cont;
  } ctl_cfg_t;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [PH_W-1:0]   warm;
    logic [PH_W-1:0]   samp;
  } dly_cfg_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               dly_we,
  input  logic [DLY_W-1:0]   dly_wdata,
  input  logic               psc_we,
  input  logic [PSC_W:0]     psc_wdata,
  output ctl_cfg_t           cfg,
  output dly_cfg_t           dly,
  output logic [PSC_W-1:0]   psc_val,
  output logic               psc_en,
  output logic               go,
  output logic               stop,
  output logic [CTL_W-1:0]   ctl_rdata,
  output logic [DLY_W-1:0]   dly_rdata,
  output logic [PSC_W:0]     psc_rdata
);

  ctl_cfg_t         cfg_q;
  dly_cfg_t         dly_q;
  logic [PSC_W-1:0] pval_q;
  logic             pen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      dly_q  <= '0;
      pval_q <= '0;
      pen_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        cfg_q.cont     <= ctl_wdata[CB_MODE];
        cfg_q.meas_abs <= ctl_wdata[CB_ABS];
        cfg_q.scale    <= ctl_wdata[CB_SCALE +: SEL_W];
        cfg_q.ch_sel   <= ctl_wdata[CB_CH +: SEL_W];
        cfg_q.ref_sel  <= ctl_wdata[CB_REF +: SEL_W];
      end
      if (dly_we) dly_q <= dly_cfg_t'(dly_wdata);
      if (psc_we) begin
        pval_q <= psc_wdata[PSC_W-1:0];
        pen_q  <= psc_wdata[PSC_W];
      end
    end
  end

  // Start and abort are strobes; abort is honoured only under the stored mode.
  assign go   = ctl_we && ctl_wdata[CB_GO];
  assign stop = ctl_we && ctl_wdata[CB_STOP] && cfg_q.cont;

  always_comb begin
    ctl_rdata                        = '0;
    ctl_rdata[CB_MODE]               = cfg_q.cont;
    ctl_rdata[CB_ABS]                = cfg_q.meas_abs;
    ctl_rdata[CB_SCALE +: SEL_W]     = cfg_q.scale;
    ctl_rdata[CB_CH +: SEL_W]        = cfg_q.ch_sel;
    ctl_rdata[CB_REF +: SEL_W]       = cfg_q.ref_sel;
  end

  assign dly_rdata = DLY_W'(dly_q);
  assign psc_rdata = {pen_q, pval_q};
  assign cfg       = cfg_q;
  assign dly       = dly_q;
  assign psc_val   = pval_q;
  assign psc_en    = pen_q;

endmodule

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             psc_en,
  input  logic [PSC_W-1:0] psc_val,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= psc_val);
  assign tick = run && (!psc_en || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || !psc_en || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int PW    = 8,
  parameter int RW    = 16,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic             cont,
  input  logic             tick,
  input  logic [PW-1:0]    warm_ticks,
  input  logic [PW-1:0]    samp_ticks,
  input  logic [RW-1:0]    rate_ticks,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             clr_done,
  output logic             warm_en,
  output logic             sample_en,
  output logic             conv_valid,
  output logic             busy,
  output logic [RES_W-1:0] data_q,
  output logic             done_q
);

  seq_state_e      st_q, st_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic [RW-1:0]   per_q, per_d;
  logic            warm_last, samp_last, per_last, capture;

  // A phase ends on the tick that brings its count to the limit (min one tick).
  assign warm_last = ({1'b0, ph_q} + (PW+1)'(1)) >= {1'b0, warm_ticks};
  assign samp_last = ({1'b0, ph_q} + (PW+1)'(1)) >= {1'b0, samp_ticks};
  assign per_last  = ({1'b0, per_q} + (RW+1)'(1)) >= {1'b0, rate_ticks};
  assign capture   = (st_q == ST_CONV) && res_valid && !stop;

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    per_d = per_q;
    if (tick && (st_q != ST_IDLE) && (per_q != '1)) per_d = per_q + 1'b1;
    if (stop) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_d  = ST_WARM;
          ph_d  = '0;
          per_d = '0;
        end
        ST_WARM: if (tick) begin
          if (warm_last) begin
            st_d = ST_SAMP;
            ph_d = '0;
          end else ph_d = ph_q + 1'b1;
        end
        ST_SAMP: if (tick) begin
          if (samp_last) begin
            st_d = ST_CONV;
            ph_d = '0;
          end else ph_d = ph_q + 1'b1;
        end
        ST_CONV: if (res_valid) st_d = cont ? ST_GAP : ST_IDLE;
        ST_GAP: begin
          if (!cont) st_d = ST_IDLE;
          else if (tick && per_last) begin
            st_d  = ST_WARM;
            ph_d  = '0;
            per_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      per_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      per_q <= per_d;
      if (capture) data_q <= res_data;
      if (capture)       done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign warm_en    = (st_q == ST_WARM);
  assign sample_en  = (st_q == ST_SAMP);
  assign conv_valid = (st_q == ST_CONV);
  assign busy       = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  input  logic               dly_we,
  input  logic [DLY_W-1:0]   dly_wdata,
  output logic [DLY_W-1:0]   dly_rdata,
  input  logic               psc_we,
  input  logic [PSC_W:0]     psc_wdata,
  output logic [PSC_W:0]     psc_rdata,
  input  logic               stat_we,
  input  logic [STAT_W-1:0]  stat_wdata,
  output logic [STAT_W-1:0]  stat_rdata,
  output logic [RES_W-1:0]   data_out,
  output logic               irq,
  output logic               busy,
  output logic [SEL_W-1:0]   ch_sel,
  output logic [SEL_W-1:0]   ref_sel,
  output logic [SEL_W-1:0]   scale_code,
  output logic               meas_abs,
  output logic               warm_en,
  output logic               sample_en,
  output logic               conv_valid,
  output logic               res_ready,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_data
);

  ctl_cfg_t         cfg;
  dly_cfg_t         dly;
  logic [PSC_W-1:0] psc_val;
  logic             psc_en, go, stop, tick, done;

  adc_seq_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dly_we(dly_we), .dly_wdata(dly_wdata),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .cfg(cfg), .dly(dly), .psc_val(psc_val), .psc_en(psc_en),
    .go(go), .stop(stop),
    .ctl_rdata(ctl_rdata), .dly_rdata(dly_rdata), .psc_rdata(psc_rdata)
  );

  adc_seq_tick #(.PSC_W(PSC_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .psc_en(psc_en), .psc_val(psc_val), .tick(tick)
  );

  adc_seq_fsm #(.PW(PH_W), .RW(RATE_W), .RES_W(RES_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .cont(cfg.cont),
    .tick(tick), .warm_ticks(dly.warm), .samp_ticks(dly.samp),
    .rate_ticks(dly.rate), .res_valid(res_valid), .res_data(res_data),
    .clr_done(stat_we && stat_wdata[0]),
    .warm_en(warm_en), .sample_en(sample_en), .conv_valid(conv_valid),
    .busy(busy), .data_q(data_out), .done_q(done)
  );

  assign res_ready  = conv_valid;
  assign irq        = done;
  assign stat_rdata = {busy, done};
  assign ch_sel     = cfg.ch_sel;
  assign ref_sel    = cfg.ref_sel;
  assign scale_code = cfg.scale;
  assign meas_abs   = cfg.meas_abs;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_we,
  input logic [CTL_W-1:0]   ctl_wdata,
  input logic [CTL_W-1:0]   ctl_rdata,
  input logic               stat_we,
  input logic [STAT_W-1:0]  stat_wdata,
  input logic [STAT_W-1:0]  stat_rdata,
  input logic [RES_W-1:0]   data_out,
  input logic               busy,
  input logic               warm_en,
  input logic               sample_en,
  input logic               conv_valid,
  input logic               res_ready,
  input logic               res_valid,
  input logic [RES_W-1:0]   res_data
);

  logic abort_req, hs;
  assign abort_req = ctl_we && ctl_wdata[CB_STOP] && ctl_rdata[CB_MODE];
  assign hs        = res_valid && res_ready;

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !res_valid && !abort_req |=> conv_valid);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !abort_req |=> (data_out == $past(res_data)) && stat_rdata[0]);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[0] && !(stat_we && stat_wdata[0]) |=> stat_rdata[0]);

  a_r5_sample_after_warm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_en) |-> $past(warm_en));

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !busy);

  a_r11_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_en || sample_en) && !abort_req |=> busy);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(ctl_we && ctl_wdata[CB_GO]) |=> !busy);

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
  .stat_rdata(stat_rdata), .data_out(data_out), .busy(busy),
  .warm_en(warm_en), .sample_en(sample_en), .conv_valid(conv_valid),
  .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
  localparam int RES_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, dly_we = 0, psc_we = 0, stat_we = 0, res_valid = 0;
  logic [15:0] ctl_wdata = '0, ctl_rdata;
  logic [31:0] dly_wdata = '0, dly_rdata;
  logic [8:0]  psc_wdata = '0, psc_rdata;
  logic [1:0]  stat_wdata = '0, stat_rdata;
  logic [RES_W-1:0] data_out, res_data = '0;
  logic irq, busy, meas_abs, warm_en, sample_en, conv_valid, res_ready;
  logic [2:0] ch_sel, ref_sel, scale_code;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_seq_top #(.RES_W(RES_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks enter and leave at a falling edge.
  task automatic wr_ctl(input logic [15:0] v);
    ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0; ctl_wdata = '0;
  endtask
  task automatic wr_dly(input logic [31:0] v);
    dly_we = 1; dly_wdata = v; @(negedge clk); dly_we = 0;
  endtask
  task automatic wr_psc(input logic [8:0] v);
    psc_we = 1; psc_wdata = v; @(negedge clk); psc_we = 0;
  endtask
  task automatic wr_stat(input logic [1:0] v);
    stat_we = 1; stat_wdata = v; @(negedge clk); stat_we = 0; stat_wdata = '0;
  endtask

  function automatic logic [15:0] ctlw(input bit mode, go, stop);
    return {13'd0, stop, go, mode};
  endfunction

  // Count strobe cycles until the convert phase is reached.
  task automatic run_to_conv(output int nw, output int ns);
    int guard = 0;
    nw = 0; ns = 0;
    while (!conv_valid && guard < 4000) begin
      nw += int'(warm_en); ns += int'(sample_en);
      @(negedge clk); guard++;
    end
  endtask

  task automatic finish_conv(input logic [RES_W-1:0] v);
    res_valid = 1; res_data = v; @(negedge clk); res_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nw, ns, t, wexp, sexp, last, prev, k;
    int rises[$];
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    // reset state
    chk(!busy && !irq && data_out == 0 && ctl_rdata == 0 && !warm_en, "R6 R7 reset", int'(busy), 0);

    // R1 R2: read-back layout and pass-through
    wr_ctl(16'hFFF9);
    chk(ctl_rdata == 16'h7779, "R1 readback", ctl_rdata, 16'h7779);
    chk(ch_sel == 7 && ref_sel == 7 && scale_code == 7 && meas_abs, "R2 pins all ones", ch_sel, 7);
    chk(!busy, "R12 no start bit", int'(busy), 0);
    wr_ctl(16'h2650);
    chk(ctl_rdata == 16'h2650, "R1 readback 2", ctl_rdata, 16'h2650);
    chk(ch_sel == 6 && ref_sel == 2 && scale_code == 5 && !meas_abs, "R2 pins", {ref_sel, ch_sel, scale_code}, 9'o265);
    repeat (5) @(negedge clk);
    chk(!busy, "R12 still idle", int'(busy), 0);

    // R13
    wr_dly(32'hA5C3_5A0F);
    chk(dly_rdata == 32'hA5C3_5A0F, "R13 timing", dly_rdata, 32'hA5C3_5A0F);
    wr_psc(9'h1FF);
    chk(psc_rdata == 9'h1FF, "R13 prescale", psc_rdata, 9'h1FF);

    // Sweep single-shot timing: R3 R4 R5 R6 R7
    for (int en = 0; en < 2; en++)
      for (int p = 0; p < 3; p++)
        for (int w = 0; w < 3; w++)
          for (int s = 0; s < 3; s++) begin
            wr_psc({en[0], p[7:0]});
            wr_dly({16'd0, w[7:0], s[7:0]});
            wr_ctl(ctlw(0, 1, 0));
            run_to_conv(nw, ns);
            t = en ? p + 1 : 1;
            wexp = (w == 0 ? 1 : w) * t;
            sexp = (s == 0 ? 1 : s) * t;
            chk(nw == wexp, "R3 R4 warm length", nw, wexp);
            chk(ns == sexp, "R3 R5 sample length", ns, sexp);
            chk(res_ready && conv_valid, "R6 ready in convert", int'(res_ready), 1);
            repeat (2) @(negedge clk);
            chk(conv_valid, "R6 request held", int'(conv_valid), 1);
            k = (en * 100 + p * 9 + w * 3 + s) & 12'hFFF;
            finish_conv(k[RES_W-1:0]);
            chk(data_out == k[RES_W-1:0] && !busy, "R6 capture", data_out, k);
            chk(irq && stat_rdata[0], "R7 done set", int'(irq), 1);
            wr_stat(2'b00);
            chk(irq, "R7 write 0 no effect", int'(irq), 1);
            wr_stat(2'b01);
            chk(!irq, "R7 clear", int'(irq), 0);
          end

    // R8: continuous spacing, T=2, W=1, S=1, R=10 -> 20 cycles
    wr_psc(9'h101);
    wr_dly({16'd10, 8'd1, 8'd1});
    wr_ctl(ctlw(1, 1, 0));
    prev = 0; last = -1;
    for (int i = 0; i < 70; i++) begin
      if (warm_en && !prev) rises.push_back(i);
      prev = int'(warm_en);
      res_valid = conv_valid;
      res_data  = RES_W'(i * 5 + 1);
      if (conv_valid) last = i * 5 + 1;
      @(negedge clk);
    end
    res_valid = 0;
    chk(rises.size() == 4, "R8 start count", rises.size(), 4);
    for (int j = 1; j < rises.size(); j++)
      chk(rises[j] - rises[j-1] == 20, "R8 period", rises[j] - rises[j-1], 20);
    chk(data_out == RES_W'(last), "R6 continuous capture", data_out, last);

    // R9: abort stops continuous run
    wr_ctl(ctlw(1, 0, 1));
    chk(!busy && !warm_en && !sample_en && !conv_valid, "R9 idle", int'(busy), 0);
    repeat (30) @(negedge clk);
    chk(!busy, "R9 no restart", int'(busy), 0);

    // R9: abort beats a result offered on the same edge
    wr_stat(2'b01);
    prev = int'(data_out);
    wr_ctl(ctlw(1, 1, 0));
    run_to_conv(nw, ns);
    res_valid = 1; res_data = 12'hABC;
    wr_ctl(ctlw(1, 0, 1));
    res_valid = 0;
    chk(!busy, "R9 abort in convert", int'(busy), 0);
    chk(data_out == RES_W'(prev) && !irq, "R9 result discarded", data_out, prev);

    // R10: abort ignored in single-shot
    wr_psc(9'h000);
    wr_dly({16'd0, 8'd3, 8'd3});
    wr_ctl(ctlw(0, 1, 0));
    @(negedge clk);
    wr_ctl(ctlw(0, 0, 1));
    chk(busy, "R10 still busy", int'(busy), 1);
    run_to_conv(nw, ns);
    finish_conv(12'h123);
    chk(irq && data_out == 12'h123, "R10 completes", data_out, 12'h123);
    wr_stat(2'b01);

    // R11: second start while busy ignored (W=2,S=2,T=1)
    wr_dly({16'd0, 8'd2, 8'd2});
    wr_ctl(ctlw(0, 1, 0));
    wr_ctl(ctlw(0, 1, 0));
    run_to_conv(nw, ns);
    chk(nw + ns == 3, "R11 phases not restarted", nw + ns, 3);
    finish_conv(12'h456);
    chk(data_out == 12'h456 && !busy, "R11 completes", data_out, 12'h456);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule